// File: doc/BRIEF.md
# Prescaled 8-bit PWM channel

This block produces one pulse-width-modulated output from a single 32-bit control word. The word carries a run bit, a level for the pin while the channel is stopped, an 8-bit reload value that divides the input clock, and an 8-bit duty value. The divided clock ticks an 8-bit phase counter, so each PWM period is 256 ticks long.

The duty value states how much of the period the pin spends at its idle level. The pin starts each period at the idle level and switches to the opposite level once the phase reaches the duty value. A reload value of zero means divide-by-256. New reload and duty values written while the channel runs wait for the next period boundary, so a period is never cut short.

Software writes the whole word through a one-cycle write strobe and reads it back at any time on a dedicated read bus.

Top module: `pwm8_channel`

## Requirements
- R1: The control word reads back exactly as last written, including the reserved bits 29:16, one cycle after the write strobe; after reset it reads 0.
- R2: While bit 31 (run) is 0, the pin equals bit 30 (idle level); after reset the pin is low.
- R3: While running, the pin is at the idle level for phase counts below the duty value (bits 7:0) and at the inverse of the idle level for counts at or above it; a duty value of 0 keeps the pin at the inverse level for the whole period.
- R4: The reload value in bits 15:8 divides the input clock by itself for values 1 to 255 and by 256 for value 0; the phase advances once per divided tick.
- R5: One period is 256 ticks: after 256 × divisor cycles the phase wraps from 255 to 0 and the pin returns to the idle level (unless duty is 0).
- R6: While stopped, the prescaler and phase counter hold at zero, so after the enabling write the pin leaves the idle level exactly duty × divisor cycles later.
- R7: Reload and duty values written while running take effect only when the phase wraps from 255 to 0; the period in progress completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to store |
| reg_rdata | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output pin |

## Verification
Every result is due a fixed number of cycles after the edge that captures a write: the read bus and the stopped-pin level change right after that edge, and the first switch to the active level follows duty × divisor cycles later, with 256 × divisor cycles per period. The bench drives inputs on falling edges and samples once per falling edge, counting samples from the first one after the capturing edge, so sample index j equals cycles since the write took effect. Active-level counts, the index of the first active sample and the level at index 256 × divisor are compared with values derived from the requirement formulas, and the deferred-update test splits its count at sample 256 to see the old and new duty.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

   // divisor minus one for a reload field; zero wraps to all ones (divide by 2**w)
   function automatic logic [7:0] reload_to_last(input logic [7:0] reload);
      return reload - 8'd1;
   endfunction

endpackage

// File: rtl/pwm8_ctrl_word.sv
module pwm8_ctrl_word #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned RLD_LSB = 8,
   parameter int unsigned DUTY_LSB = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] word_q,
   output logic [CNT_W-1:0] next_reload,
   output logic [CNT_W-1:0] next_duty
);

   logic [REG_W-1:0] word_d;

   always_comb begin
      word_d = word_q;
      if (wr) word_d = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign next_reload = word_d[RLD_LSB +: CNT_W];
   assign next_duty   = word_d[DUTY_LSB +: CNT_W];

endmodule

// File: rtl/pwm8_prescale.sv
module pwm8_prescale #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] reload,
   output logic             tick
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   // reload of zero wraps to all ones: divide by 2**CNT_W
   assign last = reload - CNT_W'(1);
   assign tick = run && (cnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/pwm8_phase.sv
module pwm8_phase #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] new_reload,
   input  logic [CNT_W-1:0] new_duty,
   output logic [CNT_W-1:0] phase,
   output logic [CNT_W-1:0] reload_sh,
   output logic [CNT_W-1:0] duty_sh
);

   logic boundary;
   logic take;

   assign boundary = tick && (phase == {CNT_W{1'b1}});
   assign take     = !run || boundary;

   always_ff @(posedge clk) begin
      if (!rst_n)      phase <= '0;
      else if (!run)   phase <= '0;
      else if (tick)   phase <= phase + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_sh <= '0;
         duty_sh   <= '0;
      end else if (take) begin
         reload_sh <= new_reload;
         duty_sh   <= new_duty;
      end
   end

endmodule

// File: rtl/pwm8_shape.sv
module pwm8_shape #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             run,
   input  logic             idle_lvl,
   input  logic [CNT_W-1:0] phase,
   input  logic [CNT_W-1:0] duty,
   output logic             pin
);

   always_comb begin
      if (!run)                pin = idle_lvl;
      else if (phase < duty)   pin = idle_lvl;
      else                     pin = !idle_lvl;
   end

endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             pwm_out
);

   localparam int unsigned RUN_BIT  = REG_W - 1;
   localparam int unsigned IDLE_BIT = REG_W - 2;
   localparam int unsigned DUTY_LSB = 0;
   localparam int unsigned RLD_LSB  = DUTY_LSB + CNT_W;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("pwm8_channel: CNT_W must be at least 2");
      end
      if (RLD_LSB + CNT_W > IDLE_BIT) begin : g_bad_map
         $error("pwm8_channel: fields overlap the control bits");
      end
   endgenerate

   logic [CNT_W-1:0] next_reload;
   logic [CNT_W-1:0] next_duty;
   logic [CNT_W-1:0] reload_sh;
   logic [CNT_W-1:0] duty_sh;
   logic [CNT_W-1:0] phase;
   logic             tick;
   logic             run;
   logic             idle_lvl;

   pwm8_ctrl_word #(
      .REG_W(REG_W), .CNT_W(CNT_W), .RLD_LSB(RLD_LSB), .DUTY_LSB(DUTY_LSB)
   ) u_word (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .word_q(reg_rdata), .next_reload(next_reload), .next_duty(next_duty)
   );

   assign run      = reg_rdata[RUN_BIT];
   assign idle_lvl = reg_rdata[IDLE_BIT];

   pwm8_prescale #(.CNT_W(CNT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .reload(reload_sh), .tick(tick)
   );

   pwm8_phase #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .new_reload(next_reload), .new_duty(next_duty),
      .phase(phase), .reload_sh(reload_sh), .duty_sh(duty_sh)
   );

   pwm8_shape #(.CNT_W(CNT_W)) u_shape (
      .run(run), .idle_lvl(idle_lvl), .phase(phase), .duty(duty_sh), .pin(pwm_out)
   );

endmodule

// File: rtl/pwm8_channel_chk.sv
module pwm8_channel_chk #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             pwm_out,
   input logic             tick,
   input logic [CNT_W-1:0] phase,
   input logic [CNT_W-1:0] reload_sh,
   input logic [CNT_W-1:0] duty_sh
);

   logic run;
   assign run = reg_rdata[REG_W-1];

   // R1
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (reg_rdata == $past(reg_wdata)));

   // R2
   stopped_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (pwm_out == reg_rdata[REG_W-2]));

   // R4
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(phase));

   // R6
   stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (phase == '0));

   // R7
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(tick && phase == {CNT_W{1'b1}})) |=> ($stable(duty_sh) && $stable(reload_sh)));

   // R3
   duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && duty_sh == '0) |-> (pwm_out != reg_rdata[REG_W-2]));

endmodule

bind pwm8_channel pwm8_channel_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .pwm_out(pwm_out), .tick(tick), .phase(phase),
   .reload_sh(reload_sh), .duty_sh(duty_sh)
);

// File: tb/sim_pwm8_channel.sv
module sim_pwm8_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pwm_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = !clk;

   pwm8_channel u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pwm_out(pwm_out)
   );

   // {idle, reload, duty}
   localparam logic [16:0] VEC [0:6] = '{
      {1'b0, 8'd1, 8'd128},
      {1'b0, 8'd1, 8'd1},
      {1'b0, 8'd2, 8'd255},
      {1'b1, 8'd3, 8'd64},
      {1'b0, 8'd1, 8'd0},
      {1'b1, 8'd4, 8'd200},
      {1'b0, 8'd0, 8'd1}
   };

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after capture
   task automatic wr(input logic [31:0] v);
      reg_wr = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 R2 reset state
      check("R1 reset word", int'(reg_rdata), 0);
      check("R2 reset pin", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 readback incl. reserved bits; R2 stopped pin follows idle bit
      wr(32'h7ABC_1234);
      check("R1 readback", int'(reg_rdata == 32'h7ABC_1234), 1);
      check("R2 stopped idle=1", int'(pwm_out), 1);
      repeat (20) @(negedge clk);
      check("R2 idle held", int'(pwm_out), 1);
      wr(32'h0);
      check("R2 idle=0", int'(pwm_out), 0);

      for (int v = 0; v < 7; v++) begin
         logic       idle;
         logic [7:0] rld;
         logic [7:0] dty;
         int div, per, exp_act, exp_first, act, first;
         logic act_lvl;
         {idle, rld, dty} = VEC[v];
         div = (rld == 8'd0) ? 256 : int'(rld);
         per = 256 * div;
         exp_act = (dty == 8'd0) ? per : (256 - int'(dty)) * div;
         exp_first = int'(dty) * div;
         act_lvl = !idle;
         act = 0;
         first = -1;
         wr({1'b1, idle, 14'h0, rld, dty});
         for (int j = 0; j < per; j++) begin
            if (pwm_out == act_lvl) begin
               act++;
               if (first < 0) first = j;
            end
            @(negedge clk);
         end
         // R3 R4 active time over one period
         check($sformatf("R3/R4 vec%0d active", v), act, exp_act);
         // R6 first switch after duty*divisor cycles
         check($sformatf("R6 vec%0d first", v), first, exp_first);
         // R5 wrap back to phase 0
         check($sformatf("R5 vec%0d wrap", v), int'(pwm_out),
               (dty == 8'd0) ? int'(act_lvl) : int'(idle));
         wr({1'b0, idle, 14'h0, rld, dty});
         check($sformatf("R2 vec%0d stop", v), int'(pwm_out), int'(idle));
      end

      // R7 deferred update: duty 128 -> 64 written mid-period
      begin
         int a0, a1;
         a0 = 0;
         a1 = 0;
         wr(32'h8000_0180);
         for (int j = 0; j < 512; j++) begin
            if (j == 10) begin
               reg_wr = 1'b1;
               reg_wdata = 32'h8000_0140;
            end else begin
               reg_wr = 1'b0;
            end
            if (pwm_out) begin
               if (j < 256) a0++;
               else a1++;
            end
            @(negedge clk);
         end
         check("R7 old period", a0, 128);
         check("R7 new period", a1, 192);
         wr(32'h0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule